// File: doc/BRIEF.md
# Adaptive Current-Reference Delay Buffer

This block sits between the input-voltage sampler and the current-reference multiplier of a digitally controlled power-factor-correction stage. Every control period a fresh input-voltage sample is written into a circular store. The value handed onward is not that newest sample but one taken a number of periods earlier. The current loop then makes the inductor current lag the line voltage by a matching amount, which cancels the leading reactive current of the input filter capacitors.

The amount of lag is chosen at run time. A quantized amplitude code for the line voltage and a quantized load code index a computed two-dimensional delay map. A lower line voltage or a heavier load gives a shorter delay, because too much lag hurts power factor more than none. A new delay takes effect only on a zero-crossing strobe, so the lag never jumps within a half cycle. Until the store has been filled once after reset, the block passes the newest sample straight through.

Top module: `cref_delay_buf`

## Requirements
- R1: After reset `delayOut` is 0, the store counts as empty and the active delay is 0 samples. With delay 0 the output equals the newest sample.
- R2: `delayOut` changes only in the cycle after a cycle with `sampleValid` high. In every other cycle it holds its value.
- R3: For the first DEPTH samples after reset, `delayOut` equals the sample written in that strobe, whatever the active delay is.
- R4: From sample index DEPTH on (0-based), a strobe with active delay D gives `delayOut` equal to the sample written D strobes earlier.
- R5: The delay is min(BASE_DELAY + VOLT_STEP*v + LOAD_STEP*(7-l), DEPTH-1). Here v is the 3-bit unsigned `voltCode`, l is the 3-bit unsigned `loadCode`, and 7 is the heaviest load. With the defaults: v=3,l=2 gives 40; v=1,l=2 gives 32; v=1,l=6 gives 16; v=0,l=7 gives 8.
- R6: A lower voltage code, or a heavier load code, never gives a longer delay.
- R7: The delay is latched from the codes only in a cycle with `zeroCross` high. Changes to the codes at other times have no effect on the output.
- R8: A table value above DEPTH-1 is clamped to DEPTH-1. With the defaults, v=7,l=0 gives 63.
- R9: The write position advances by one per sample and wraps modulo DEPTH. The delayed output stays correct across the wrap.
- R10: When `zeroCross` and `sampleValid` are high in the same cycle, that sample uses the previously active delay. The new delay applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe: a new voltage sample is on `sampleIn` |
| sampleIn | input | DATA_W | Sensed input-voltage sample |
| zeroCross | input | 1 | One-cycle line zero-crossing strobe; latches a new delay |
| voltCode | input | 3 | Quantized line-voltage amplitude code |
| loadCode | input | 3 | Quantized output-load code, 7 = heaviest |
| delayOut | output | DATA_W | Delayed voltage sample for the current reference |

## Verification
The bench targets the boundary between the pass-through phase and the delayed phase at sample DEPTH. A fill flag that is off by one there gives either a stale value from the unwritten store or a sample one position too new. It also drives the largest delay across several pointer wraps. A modulo subtraction that gets the borrow wrong then reads an unrelated location. Two further cases check the timing of the delay update: code changes between zero crossings, and a zero crossing that coincides with a sample strobe. A design that latched the codes continuously, or applied the new delay one sample early, would return a sample from the wrong age.

// File: rtl/cref_delay_pkg.sv
package cref_delay_pkg;

  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

  typedef struct packed {
    logic wrEn;    // store the incoming sample and reload the output
    logic bypass;  // hand the newest sample straight through
  } bufStrobe_t;

  // Delay in samples for one operating point, clamped to the store span.
  function automatic int unsigned lookupDelay(
    input logic [CODE_W-1:0] vCode,
    input logic [CODE_W-1:0] lCode,
    input int unsigned       baseDelay,
    input int unsigned       voltStep,
    input int unsigned       loadStep,
    input int unsigned       maxDelay
  );
    int unsigned raw;
    raw = baseDelay + voltStep * int'(vCode) + loadStep * (CODE_MAX - int'(lCode));
    return (raw > maxDelay) ? maxDelay : raw;
  endfunction

endpackage

// File: rtl/cref_delay_ctrl.sv
module cref_delay_ctrl
  import cref_delay_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned BASE_DELAY = 8,
  parameter int unsigned VOLT_STEP  = 4,
  parameter int unsigned LOAD_STEP  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              zeroCross,
  input  logic [CODE_W-1:0] voltCode,
  input  logic [CODE_W-1:0] loadCode,
  output bufStrobe_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W:0]   SPAN      = (ADDR_W + 1)'(DEPTH);

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] activeDelay;
  logic [ADDR_W-1:0] nextDelay;
  logic              filled;

  assign nextDelay = ADDR_W'(lookupDelay(voltCode, loadCode, BASE_DELAY,
                                         VOLT_STEP, LOAD_STEP, DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      filled      <= 1'b0;
      activeDelay <= '0;
    end else begin
      if (sampleValid) begin
        wrPtr <= (wrPtr == LAST_ADDR) ? '0 : wrPtr + 1'b1;
        if (wrPtr == LAST_ADDR) filled <= 1'b1;
      end
      if (zeroCross) activeDelay <= nextDelay;
    end
  end

  // Trail the write position by the active delay, modulo DEPTH.
  always_comb begin
    if (wrPtr >= activeDelay)
      rdAddr = wrPtr - activeDelay;
    else
      rdAddr = ADDR_W'({1'b0, wrPtr} + SPAN - {1'b0, activeDelay});
  end

  assign wrAddr      = wrPtr;
  assign strb.wrEn   = sampleValid;
  assign strb.bypass = !filled || (activeDelay == '0);

endmodule

// File: rtl/cref_delay_dpath.sv
module cref_delay_dpath
  import cref_delay_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] delayOut
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wrAddr] <= sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      delayOut <= '0;
    else if (strb.wrEn)
      delayOut <= strb.bypass ? sampleIn : store[rdAddr];
  end

endmodule

// File: rtl/cref_delay_buf.sv
module cref_delay_buf
  import cref_delay_pkg::*;
#(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned BASE_DELAY = 8,
  parameter int unsigned VOLT_STEP  = 4,
  parameter int unsigned LOAD_STEP  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              zeroCross,
  input  logic [2:0]        voltCode,
  input  logic [2:0]        loadCode,
  output logic [DATA_W-1:0] delayOut
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);

  bufStrobe_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  cref_delay_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_DELAY(BASE_DELAY),
    .VOLT_STEP(VOLT_STEP), .LOAD_STEP(LOAD_STEP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .zeroCross(zeroCross),
    .voltCode(voltCode), .loadCode(loadCode),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  cref_delay_dpath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .sampleIn(sampleIn), .delayOut(delayOut)
  );

endmodule

// File: rtl/cref_delay_chk.sv
module cref_delay_chk
  import cref_delay_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleIn,
  input logic              zeroCross,
  input logic [DATA_W-1:0] delayOut,
  input bufStrobe_t        strb,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W:0]   SPAN      = (ADDR_W + 1)'(DEPTH);

  logic [ADDR_W:0]   seenCnt;
  logic [ADDR_W-1:0] distance;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenCnt <= '0;
    else if (sampleValid && seenCnt != SPAN) seenCnt <= seenCnt + 1'b1;
  end

  always_comb begin
    if (wrAddr >= rdAddr) distance = wrAddr - rdAddr;
    else distance = ADDR_W'({1'b0, wrAddr} + SPAN - {1'b0, rdAddr});
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(delayOut)); // R2

  AST_PREFILL_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && seenCnt != SPAN) |=> delayOut == $past(sampleIn)); // R3

  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> wrAddr == (($past(wrAddr) == LAST_ADDR) ? '0 : $past(wrAddr) + 1'b1)); // R9

  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !zeroCross |=> $stable(distance)); // R7

  AST_TRAIL_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.bypass) |-> distance != '0); // R8

endmodule

bind cref_delay_buf cref_delay_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
  .zeroCross(zeroCross), .delayOut(delayOut), .strb(strb),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/test_cref_delay_buf.sv
module test_cref_delay_buf;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleValid;
  logic [11:0] sampleIn;
  logic        zeroCross;
  logic [2:0]  voltCode;
  logic [2:0]  loadCode;
  logic [11:0] delayOut;

  int checks = 0;
  int errors = 0;
  int hist [0:1023];
  int nSamp = 0;
  int curDelay = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  cref_delay_buf i_cref_delay_buf (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .zeroCross(zeroCross), .voltCode(voltCode), .loadCode(loadCode),
    .delayOut(delayOut)
  );

  function automatic int refDelay(int v, int l);
    int r;
    r = 8 + 4 * v + 4 * (7 - l);
    return (r > DEPTH - 1) ? DEPTH - 1 : r;
  endfunction

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expectedOut(int idx, int d);
    return (idx < DEPTH || d == 0) ? hist[idx] : hist[idx - d];
  endfunction

  task automatic pushCheck(string req);
    int val;
    val = (nSamp * 37 + 5) % 4096;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = 12'(val);
    @(negedge clk);
    sampleValid = 1'b0;
    hist[nSamp] = val;
    checkEq(req, int'(delayOut), expectedOut(nSamp, curDelay));
    nSamp++;
  endtask

  task automatic doZc(int v, int l);
    @(negedge clk);
    zeroCross = 1'b1;
    voltCode  = 3'(v);
    loadCode  = 3'(l);
    @(negedge clk);
    zeroCross = 1'b0;
    curDelay  = refDelay(v, l);
  endtask

  task automatic tReset();
    checkEq("R1 reset output", int'(delayOut), 0);
  endtask

  task automatic tPrefill();
    for (int i = 0; i < DEPTH; i++) pushCheck("R3 prefill passthrough");
  endtask

  task automatic tZeroDelay();
    for (int i = 0; i < 3; i++) pushCheck("R1 zero delay after fill");
  endtask

  task automatic tTableDelay();
    doZc(3, 2);
    checkEq("R5 table value v3 l2", curDelay, 40);
    for (int i = 0; i < 3; i++) pushCheck("R4 R5 delayed sample");
  endtask

  task automatic tHold();
    int held;
    held = int'(delayOut);
    repeat (6) @(negedge clk);
    checkEq("R2 hold without strobe", int'(delayOut), held);
  endtask

  task automatic tIgnoreCodes();
    @(negedge clk);
    voltCode = 3'd7;
    loadCode = 3'd0;
    for (int i = 0; i < 2; i++) pushCheck("R7 codes ignored between crossings");
  endtask

  task automatic tMonotonic();
    doZc(1, 2);
    pushCheck("R6 lower voltage shorter delay");
    doZc(1, 6);
    pushCheck("R6 heavier load shorter delay");
  endtask

  task automatic tClampWrap();
    doZc(7, 0);
    checkEq("R8 clamp value", curDelay, 63);
    for (int i = 0; i < 140; i++) pushCheck("R8 R9 clamped delay across wrap");
  endtask

  task automatic tSameCycle();
    int val;
    val = (nSamp * 37 + 5) % 4096;
    @(negedge clk);
    zeroCross   = 1'b1;
    voltCode    = 3'd0;
    loadCode    = 3'd7;
    sampleValid = 1'b1;
    sampleIn    = 12'(val);
    @(negedge clk);
    zeroCross   = 1'b0;
    sampleValid = 1'b0;
    hist[nSamp] = val;
    checkEq("R10 coincident sample keeps old delay", int'(delayOut),
            expectedOut(nSamp, curDelay));
    nSamp++;
    curDelay = refDelay(0, 7);
    pushCheck("R10 new delay from next sample");
  endtask

  initial begin
    rstN = 1'b0;
    sampleValid = 1'b0;
    sampleIn = '0;
    zeroCross = 1'b0;
    voltCode = '0;
    loadCode = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPrefill();
    tZeroDelay();
    tTableDelay();
    tHold();
    tIgnoreCodes();
    tMonotonic();
    tClampWrap();
    tSameCycle();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule